// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a small, fully associative cache of page translations. Each slot holds a virtual page tag, a physical page number, an address-space identifier, a global flag that makes the slot match in any address space, and per-privilege-mode read and write enable masks. It also holds two trap flags that ask for a fault on a read or on a write. A requester presents a virtual page and the current address-space identifier. One cycle later the block reports hit or miss, the index of the winning slot and its stored fields. Deciding whether the access is allowed is left to the consumer.

New translations are written at a rotating replacement pointer, which overwrites whatever that slot held. The pointer's slot is also visible on a separate read port that can step the pointer on request. Three invalidation commands keep the contents coherent with the page tables:
- wipe everything;
- drop every non-global slot, for an address-space switch;
- drop the slots that one page would hit under one address-space identifier.

Top module: `asn_tlb`

## Requirements
- R1: During and after a synchronous active-low reset every slot is invalid, the replacement pointer is 0, and the registered lookup result shows a miss.
- R2: A lookup hits only on a valid slot whose tag equals the presented page and which is either global or carries the presented address-space identifier.
- R3: The lookup result appears on the outputs after the next rising clock edge. It reflects the contents before any write made on that same edge. When several slots match, the lowest index is reported.
- R4: An accepted insert writes the slot at the replacement pointer, marks it valid with the new page as tag, and advances the pointer by one. The pointer wraps from ENTRIES-1 to 0.
- R5: Inserting over a valid slot evicts its old mapping, which no longer hits.
- R6: Flush-all invalidates every slot and returns the pointer to 0.
- R7: Process flush invalidates every non-global slot and leaves global slots valid.
- R8: Address flush invalidates every valid slot that the given page and address-space identifier would hit under the rule of R2, global slots included.
- R9: An insert requested in the same cycle as any flush is dropped: nothing is written and the pointer does not advance for it.
- R10: The read port shows the slot at the replacement pointer combinationally. The pointer advances on the step input or an accepted insert, by exactly one when both occur, and holds otherwise.
- R11: With the lookup request low, the next registered result is a miss, and on a miss the physical page, masks and flags read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page to translate |
| lk_asn | input | ASN_W | Current address-space identifier |
| lk_hit | output | 1 | Registered hit flag |
| lk_idx | output | IW | Index of the winning slot |
| lk_ppn | output | PPN_W | Physical page of the winning slot |
| lk_rd_en | output | MODES | Read enable per mode |
| lk_wr_en | output | MODES | Write enable per mode |
| lk_flt_rd | output | 1 | Fault-on-read flag |
| lk_flt_wr | output | 1 | Fault-on-write flag |
| lk_glob | output | 1 | Global flag of the winning slot |
| ins_en | input | 1 | Insert request |
| ins_vpn | input | VPN_W | Tag of the new slot |
| ins_ppn | input | PPN_W | Physical page of the new slot |
| ins_asn | input | ASN_W | Address-space identifier of the new slot |
| ins_glob | input | 1 | Global flag of the new slot |
| ins_rd_en | input | MODES | Read enable mask of the new slot |
| ins_wr_en | input | MODES | Write enable mask of the new slot |
| ins_flt_rd | input | 1 | Fault-on-read flag of the new slot |
| ins_flt_wr | input | 1 | Fault-on-write flag of the new slot |
| fl_all | input | 1 | Invalidate all slots |
| fl_proc | input | 1 | Invalidate non-global slots |
| fl_addr | input | 1 | Invalidate slots matching fl_vpn/fl_asn |
| fl_vpn | input | VPN_W | Page for the address flush |
| fl_asn | input | ASN_W | Address-space identifier for the address flush |
| nu_adv | input | 1 | Step the replacement pointer |
| nu_idx | output | IW | Replacement pointer |
| nu_valid | output | 1 | Valid bit of the slot at the pointer |
| nu_vpn | output | VPN_W | Tag of the slot at the pointer |
| nu_ppn | output | PPN_W | Physical page of the slot at the pointer |
| nu_asn | output | ASN_W | Address-space identifier of the slot at the pointer |
| nu_glob | output | 1 | Global flag of the slot at the pointer |

## Verification
Lookups are drawn from a narrow range of pages and identifiers, so the same tag often sits in several slots. This separates a wrong priority order from a wrong match rule. Directed cases place one page in three slots under different identifiers, one of them global. They show whether the identifier comparison and the global override are each honoured, by lookup and by address flush alike. Mixed cycles that insert and flush at once catch a design that lets the insert through. A run of inserts past the slot count exposes wrap and eviction errors. A long random mix with a low flush rate then compares every registered lookup and every read-port value against the bench's model.

// File: rtl/tlb_pkg.sv
// Shared widths and the slot record of the translation buffer.
// Assumes every instance of the buffer uses these field widths.
package tlb_pkg;
    localparam int VPN_W = 20;
    localparam int PPN_W = 22;
    localparam int ASN_W = 8;
    localparam int MODES = 4;

    typedef struct packed {
        logic             valid;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
        logic [ASN_W-1:0] asn;
        logic             glob;
        logic [MODES-1:0] rd_en;
        logic [MODES-1:0] wr_en;
        logic             flt_rd;
        logic             flt_wr;
    } tlb_entry_t;
endpackage

// File: rtl/tlb_match.sv
// Compares one page/identifier pair against every slot and picks the
// lowest matching index. Purely combinational; assumes ENTRIES >= 2.
module tlb_match #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = tlb_pkg::VPN_W,
    parameter int ASN_W   = tlb_pkg::ASN_W,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]            vld,
    input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
    input  logic [ENTRIES-1:0][ASN_W-1:0] asns,
    input  logic [ENTRIES-1:0]            globs,
    input  logic [VPN_W-1:0]              key_vpn,
    input  logic [ASN_W-1:0]              key_asn,
    output logic [ENTRIES-1:0]            hit_vec,
    output logic                          any,
    output logic [IW-1:0]                 idx
);
    // Per-slot compare: tag equal and (global or same identifier).
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = vld[g] && (tags[g] == key_vpn) &&
                            (globs[g] || (asns[g] == key_asn));
    end

    assign any = |hit_vec;

    // Priority encoder: scanning downward leaves the lowest match.
    always_comb begin
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/tlb_ptr.sv
// Rotating replacement pointer. Clear wins over step; a step adds one
// and wraps at ENTRIES-1. Assumes step is already gated by the caller.
module tlb_ptr #(
    parameter int ENTRIES = 16,
    localparam int IW     = $clog2(ENTRIES),
    localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    output logic [IW-1:0] ptr
);
    // Pointer register: reset/clear to 0, otherwise step with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) ptr <= '0;
        else if (step)       ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end

    p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (ptr == '0));
    p_step_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && step) |=>
            (ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1)));
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !step) |=> $stable(ptr));
endmodule

// File: rtl/tlb_store.sv
// Slot array. Applies flush-all, process flush and a per-slot kill
// vector, or else one accepted write. Assumes wr_en is already
// suppressed by the caller whenever any flush is active.
module tlb_store #(
    parameter int ENTRIES = 16,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [IW-1:0]                       wr_idx,
    input  tlb_pkg::tlb_entry_t                 wr_data,
    input  logic                                fl_all,
    input  logic                                fl_proc,
    input  logic [ENTRIES-1:0]                  kill_vec,
    output tlb_pkg::tlb_entry_t [ENTRIES-1:0]   slots
);
    logic [ENTRIES-1:0] vld_vec;
    logic [ENTRIES-1:0] glob_vec;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        assign vld_vec[g]  = slots[g].valid;
        assign glob_vec[g] = slots[g].glob;

        // Slot register: reset, invalidate, or take the new record.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slots[g] <= '0;
            end else if (fl_all) begin
                slots[g].valid <= 1'b0;
            end else if ((fl_proc && !slots[g].glob) || kill_vec[g]) begin
                slots[g].valid <= 1'b0;
            end else if (wr_en && (wr_idx == IW'(g))) begin
                slots[g]       <= wr_data;
                slots[g].valid <= 1'b1;
            end
        end
    end

    p_wipe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fl_all |=> (vld_vec == '0));
    p_no_new_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_all || fl_proc || (|kill_vec)) |=> ((vld_vec & ~$past(vld_vec)) == '0));
    p_global_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_proc && !fl_all && (kill_vec == '0)) |=>
            ((vld_vec & glob_vec) == $past(vld_vec & glob_vec)));
    p_written_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> vld_vec[$past(wr_idx)]);
endmodule

// File: rtl/asn_tlb.sv
// Fully associative translation buffer tagged with address-space
// identifiers. Lookup is matched combinationally and registered; insert
// goes to a rotating pointer; three flush kinds; a read port shows the
// pointer slot. Assumes ENTRIES is a power of two, at least 2.
module asn_tlb #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = tlb_pkg::VPN_W,
    parameter int PPN_W   = tlb_pkg::PPN_W,
    parameter int ASN_W   = tlb_pkg::ASN_W,
    parameter int MODES   = tlb_pkg::MODES,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_req,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [ASN_W-1:0] lk_asn,
    output logic             lk_hit,
    output logic [IW-1:0]    lk_idx,
    output logic [PPN_W-1:0] lk_ppn,
    output logic [MODES-1:0] lk_rd_en,
    output logic [MODES-1:0] lk_wr_en,
    output logic             lk_flt_rd,
    output logic             lk_flt_wr,
    output logic             lk_glob,
    input  logic             ins_en,
    input  logic [VPN_W-1:0] ins_vpn,
    input  logic [PPN_W-1:0] ins_ppn,
    input  logic [ASN_W-1:0] ins_asn,
    input  logic             ins_glob,
    input  logic [MODES-1:0] ins_rd_en,
    input  logic [MODES-1:0] ins_wr_en,
    input  logic             ins_flt_rd,
    input  logic             ins_flt_wr,
    input  logic             fl_all,
    input  logic             fl_proc,
    input  logic             fl_addr,
    input  logic [VPN_W-1:0] fl_vpn,
    input  logic [ASN_W-1:0] fl_asn,
    input  logic             nu_adv,
    output logic [IW-1:0]    nu_idx,
    output logic             nu_valid,
    output logic [VPN_W-1:0] nu_vpn,
    output logic [PPN_W-1:0] nu_ppn,
    output logic [ASN_W-1:0] nu_asn,
    output logic             nu_glob
);
    import tlb_pkg::*;

    tlb_entry_t [ENTRIES-1:0]            slots;
    logic       [ENTRIES-1:0]            vld;
    logic       [ENTRIES-1:0]            globs;
    logic       [ENTRIES-1:0][VPN_W-1:0] tags;
    logic       [ENTRIES-1:0][ASN_W-1:0] asns;

    logic [ENTRIES-1:0] lk_vec, fl_vec;
    logic               lk_any, fl_any_hit;
    logic [IW-1:0]      lk_sel, fl_sel;
    logic               any_flush, ins_ok;
    logic [IW-1:0]      ptr;
    tlb_entry_t         new_rec;
    tlb_entry_t         win;

    // Split slot records into the vectors the matchers compare.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_split
        assign vld[g]   = slots[g].valid;
        assign globs[g] = slots[g].glob;
        assign tags[g]  = slots[g].vpn;
        assign asns[g]  = slots[g].asn;
    end

    // Any flush blocks the insert of the same cycle.
    assign any_flush = fl_all || fl_proc || fl_addr;
    assign ins_ok    = ins_en && !any_flush;

    // Record assembled from the insert inputs.
    always_comb begin
        new_rec        = '0;
        new_rec.valid  = 1'b1;
        new_rec.vpn    = ins_vpn;
        new_rec.ppn    = ins_ppn;
        new_rec.asn    = ins_asn;
        new_rec.glob   = ins_glob;
        new_rec.rd_en  = ins_rd_en;
        new_rec.wr_en  = ins_wr_en;
        new_rec.flt_rd = ins_flt_rd;
        new_rec.flt_wr = ins_flt_wr;
    end

    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_lk_match (
        .vld(vld), .tags(tags), .asns(asns), .globs(globs),
        .key_vpn(lk_vpn), .key_asn(lk_asn),
        .hit_vec(lk_vec), .any(lk_any), .idx(lk_sel)
    );

    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_fl_match (
        .vld(vld), .tags(tags), .asns(asns), .globs(globs),
        .key_vpn(fl_vpn), .key_asn(fl_asn),
        .hit_vec(fl_vec), .any(fl_any_hit), .idx(fl_sel)
    );

    tlb_ptr #(.ENTRIES(ENTRIES)) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .clear(fl_all), .step(ins_ok || nu_adv), .ptr(ptr)
    );

    tlb_store #(.ENTRIES(ENTRIES)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(ins_ok), .wr_idx(ptr), .wr_data(new_rec),
        .fl_all(fl_all), .fl_proc(fl_proc),
        .kill_vec(fl_addr ? fl_vec : '0),
        .slots(slots)
    );

    // Winning slot, or an all-zero record on a miss or idle request.
    assign win = (lk_req && lk_any) ? slots[lk_sel] : '0;

    // Lookup result register: one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_hit    <= 1'b0;
            lk_idx    <= '0;
            lk_ppn    <= '0;
            lk_rd_en  <= '0;
            lk_wr_en  <= '0;
            lk_flt_rd <= 1'b0;
            lk_flt_wr <= 1'b0;
            lk_glob   <= 1'b0;
        end else begin
            lk_hit    <= lk_req && lk_any;
            lk_idx    <= (lk_req && lk_any) ? lk_sel : '0;
            lk_ppn    <= win.ppn;
            lk_rd_en  <= win.rd_en;
            lk_wr_en  <= win.wr_en;
            lk_flt_rd <= win.flt_rd;
            lk_flt_wr <= win.flt_wr;
            lk_glob   <= win.glob;
        end
    end

    // Read port: the slot under the replacement pointer.
    assign nu_idx   = ptr;
    assign nu_valid = slots[ptr].valid;
    assign nu_vpn   = slots[ptr].vpn;
    assign nu_ppn   = slots[ptr].ppn;
    assign nu_asn   = slots[ptr].asn;
    assign nu_glob  = slots[ptr].glob;

    p_idle_miss_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !lk_hit);
    p_lowest_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_any |-> (lk_vec[lk_sel] &&
                    ((lk_vec & ((ENTRIES'(1) << lk_sel) - 1'b1)) == '0)));
    p_flush_hit_gone_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_addr && fl_any_hit) |=> !vld[$past(fl_sel)]);
endmodule

// File: tb/tb_asn_tlb.sv
module tb_asn_tlb;
    localparam int N  = 16;
    localparam int VW = 20, PW = 22, AW = 8, MW = 4;
    localparam int IW = $clog2(N);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          lk_req = 0;
    logic [VW-1:0] lk_vpn = '0;
    logic [AW-1:0] lk_asn = '0;
    logic          lk_hit;
    logic [IW-1:0] lk_idx;
    logic [PW-1:0] lk_ppn;
    logic [MW-1:0] lk_rd_en, lk_wr_en;
    logic          lk_flt_rd, lk_flt_wr, lk_glob;
    logic          ins_en = 0;
    logic [VW-1:0] ins_vpn = '0;
    logic [PW-1:0] ins_ppn = '0;
    logic [AW-1:0] ins_asn = '0;
    logic          ins_glob = 0;
    logic [MW-1:0] ins_rd_en = '0, ins_wr_en = '0;
    logic          ins_flt_rd = 0, ins_flt_wr = 0;
    logic          fl_all = 0, fl_proc = 0, fl_addr = 0;
    logic [VW-1:0] fl_vpn = '0;
    logic [AW-1:0] fl_asn = '0;
    logic          nu_adv = 0;
    logic [IW-1:0] nu_idx;
    logic          nu_valid;
    logic [VW-1:0] nu_vpn;
    logic [PW-1:0] nu_ppn;
    logic [AW-1:0] nu_asn;
    logic          nu_glob;

    asn_tlb #(.ENTRIES(N)) dut (.*);

    // Reference model of the slot array.
    bit            mv  [N];
    logic [VW-1:0] mvpn[N];
    logic [PW-1:0] mppn[N];
    logic [AW-1:0] masn[N];
    bit            mg  [N];
    logic [MW-1:0] mrd [N], mwr[N];
    bit            mfr [N], mfw[N];
    int            mptr = 0;
    int            n_chk = 0, n_fail = 0;
    bit            done = 0;

    function automatic int ref_find(logic [VW-1:0] v, logic [AW-1:0] a);
        for (int i = 0; i < N; i++)
            if (mv[i] && mvpn[i] == v && (mg[i] || masn[i] == a)) return i;
        return -1;
    endfunction

    task automatic chk(string tag, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One clock: predict, update model, clock, compare.
    task automatic tick(string tag);
        int  e = lk_req ? ref_find(lk_vpn, lk_asn) : -1;
        bit  ehit = (e >= 0);
        longint eidx = ehit ? e : 0;
        longint eppn = ehit ? mppn[e] : 0;
        longint erd  = ehit ? mrd[e] : 0;
        longint ewr  = ehit ? mwr[e] : 0;
        longint efr  = ehit ? mfr[e] : 0;
        longint efw  = ehit ? mfw[e] : 0;
        longint eg   = ehit ? mg[e] : 0;
        bit fl_any = fl_all || fl_proc || fl_addr;
        bit kill[N];
        bit ins_ok = ins_en && !fl_any;
        for (int i = 0; i < N; i++)
            kill[i] = fl_addr && mv[i] && mvpn[i] == fl_vpn && (mg[i] || masn[i] == fl_asn);
        if (fl_all) begin
            for (int i = 0; i < N; i++) mv[i] = 0;
            mptr = 0;
        end else begin
            for (int i = 0; i < N; i++)
                if ((fl_proc && !mg[i]) || kill[i]) mv[i] = 0;
            if (ins_ok) begin
                mv[mptr] = 1; mvpn[mptr] = ins_vpn; mppn[mptr] = ins_ppn;
                masn[mptr] = ins_asn; mg[mptr] = ins_glob; mrd[mptr] = ins_rd_en;
                mwr[mptr] = ins_wr_en; mfr[mptr] = ins_flt_rd; mfw[mptr] = ins_flt_wr;
            end
            if (ins_ok || nu_adv) mptr = (mptr + 1) % N;
        end
        @(posedge clk);
        #1;
        chk(tag, "lk_hit", lk_hit, ehit);
        chk(tag, "lk_idx", lk_idx, eidx);
        chk(tag, "lk_ppn", lk_ppn, eppn);
        if (erd != lk_rd_en || ewr != lk_wr_en || efr != lk_flt_rd ||
            efw != lk_flt_wr || eg != lk_glob)
            chk(tag, "lk_fields", {lk_rd_en, lk_wr_en, lk_flt_rd, lk_flt_wr, lk_glob},
                {erd[MW-1:0], ewr[MW-1:0], efr[0], efw[0], eg[0]});
        chk("R10", "nu_idx", nu_idx, mptr);
        chk("R10", "nu_valid", nu_valid, mv[mptr]);
        if (mv[mptr]) begin
            chk("R10", "nu_vpn", nu_vpn, mvpn[mptr]);
            chk("R10", "nu_ppn", nu_ppn, mppn[mptr]);
            chk("R10", "nu_asn", nu_asn, masn[mptr]);
            chk("R10", "nu_glob", nu_glob, mg[mptr]);
        end
        @(negedge clk);
    endtask

    task automatic idle();
        lk_req = 0; ins_en = 0; fl_all = 0; fl_proc = 0; fl_addr = 0; nu_adv = 0;
    endtask

    task automatic put(int v, int a, bit g, int p);
        ins_en = 1; ins_vpn = VW'(v); ins_asn = AW'(a); ins_glob = g;
        ins_ppn = PW'(p); ins_rd_en = MW'(p); ins_wr_en = MW'(p >> 4);
        ins_flt_rd = p[1]; ins_flt_wr = p[2];
    endtask

    task automatic look(int v, int a);
        lk_req = 1; lk_vpn = VW'(v); lk_asn = AW'(a);
    endtask

    // Watchdog.
    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5678));
        for (int i = 0; i < N; i++) begin
            mv[i] = 0; mvpn[i] = '0; mppn[i] = '0; masn[i] = '0; mg[i] = 0;
            mrd[i] = '0; mwr[i] = '0; mfr[i] = 0; mfw[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state.
        chk("R1", "lk_hit", lk_hit, 0);
        chk("R1", "nu_idx", nu_idx, 0);
        chk("R1", "nu_valid", nu_valid, 0);
        look(5, 1); tick("R1");

        // R4: three slots share page 5.
        idle(); put(5, 1, 0, 'h111); tick("R4");
        idle(); put(5, 2, 0, 'h222); tick("R4");
        idle(); put(5, 9, 1, 'h333); tick("R4");
        // R2, R3: identifier rule, global override, lowest index.
        idle(); look(5, 2); tick("R2");
        idle(); look(5, 1); tick("R3");
        idle(); look(5, 3); tick("R2");
        idle(); look(6, 2); tick("R2");
        // R3: lookup in the same cycle as an insert sees old contents.
        idle(); look(7, 4); put(7, 4, 0, 'h444); tick("R3");
        idle(); look(7, 4); tick("R3");
        // R11: request low.
        idle(); lk_req = 0; lk_vpn = 5; lk_asn = 2; tick("R11");
        // R8: address flush kills slot 0 and the global slot 2.
        idle(); fl_addr = 1; fl_vpn = 5; fl_asn = 1; tick("R8");
        idle(); look(5, 1); tick("R8");
        idle(); look(5, 2); tick("R8");
        // R9: insert dropped under process flush.
        idle(); put(8, 2, 1, 'h555); fl_proc = 1; tick("R9");
        idle(); look(8, 2); tick("R9");
        // R7: process flush keeps global slots.
        idle(); put(10, 3, 1, 'h666); tick("R7");
        idle(); put(11, 3, 0, 'h777); tick("R7");
        idle(); fl_proc = 1; tick("R7");
        idle(); look(10, 7); tick("R7");
        idle(); look(11, 3); tick("R7");
        // R10: step without insert, hold, step with insert.
        idle(); nu_adv = 1; tick("R10");
        idle(); tick("R10");
        idle(); nu_adv = 1; put(12, 0, 0, 'h888); tick("R10");
        // R4, R5: wrap and evict.
        for (int k = 0; k < N + 2; k++) begin
            idle(); put(100 + k, 1, 0, 'h1000 + k); tick("R4");
        end
        idle(); look(100, 1); tick("R5");
        idle(); look(101, 1); tick("R5");
        idle(); look(100 + N + 1, 1); tick("R5");
        // R6: flush-all wins over insert and step.
        idle(); fl_all = 1; put(200, 1, 1, 'h9); nu_adv = 1; tick("R6");
        idle(); look(100 + N, 1); tick("R6");

        // Random mix on a narrow key space.
        for (int k = 0; k < 3000; k++) begin
            int r = $urandom_range(0, 99);
            idle();
            if ($urandom_range(0, 3) != 0) look($urandom_range(0, 7), $urandom_range(0, 3));
            if ($urandom_range(0, 2) == 0)
                put($urandom_range(0, 7), $urandom_range(0, 3), $urandom_range(0, 4) == 0,
                    $urandom_range(0, 32'hFFFF));
            nu_adv = ($urandom_range(0, 9) == 0);
            fl_all  = (r < 2);
            fl_proc = (r >= 2 && r < 6);
            fl_addr = (r >= 5 && r < 12);
            fl_vpn = VW'($urandom_range(0, 7));
            fl_asn = AW'($urandom_range(0, 3));
            tick("R2");
        end

        idle();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule